// File: doc/BRIEF.md
# Sequential Signed Multiplier with Condition Flags

This unit carries out the multiply step of a 16-bit minicomputer-style instruction set. It accepts two two's-complement words and one bit giving the parity of the destination register number. It works for a fixed number of cycles and then presents a 32-bit signed product as a high and a low word. With the product it gives a two-bit write enable and the four condition flags negative, zero, overflow and carry.

Inside, the signs are removed first. The magnitudes are multiplied by an iterative right-shifting shift-and-add loop that runs one pass more than the word width. The double-word result is negated at the end only when the operand signs differ. The carry flag reports that the signed product does not fit in a single word. An odd destination register keeps only the low word. An even one receives the high word in register n and the low word in register n+1.

Top module: `mulseq_top`

## Requirements
- R1: Out of reset `ready` is 1 and `busy`, `done`, `res_hi`, `res_lo`, `wr_en` and all flags are 0.
- R2: While idle, `ready` is 1. A clock edge with `start` high and `ready` high accepts the operands, and from the next cycle `busy` is 1 and `ready` is 0 until the result is presented.
- R3: A `start` while `busy` is high is ignored. The operands it carries are not captured, and no extra `done` pulse follows.
- R4: `done` is a one-cycle pulse. It is first visible 18 clock edges after the accepting edge (word width plus two).
- R5: At `done`, `{res_hi, res_lo}` equals the 32-bit signed product of `op_a` and `op_b`, including operands of -32768.
- R6: `flag_z` is 1 exactly when the whole 32-bit product is zero.
- R7: `flag_n` equals bit 31 of the 32-bit product.
- R8: `flag_v` is always 0 at `done`.
- R9: `flag_c` is 1 exactly when `res_hi` differs from 16 copies of bit 15 of `res_lo`.
- R10: `wr_en` bit 1 enables the high word into register n and bit 0 enables the low word. An even destination (`dst_odd`=0) gives 2'b11. An odd destination gives 2'b01.
- R11: `res_hi`, `res_lo`, `wr_en` and the flags keep their values from one `done` to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiply with the present operands |
| op_a | input | 16 | First operand, two's complement |
| op_b | input | 16 | Second operand, two's complement |
| dst_odd | input | 1 | Destination register number is odd |
| ready | output | 1 | Unit idle and able to take operands |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse: result and flags are valid |
| res_hi | output | 16 | High word of the signed product |
| res_lo | output | 16 | Low word of the signed product |
| wr_en | output | 2 | Word write enables: bit 1 high word, bit 0 low word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag, always cleared |
| flag_c | output | 1 | Product does not fit in one word |

## Verification
Some properties are checked on every cycle. `done` never lasts two cycles. An accepted start always raises `busy`. The outputs never change between pulses. The zero flag never appears together with the negative or carry flag. The magnitude loop never leaves a carry above its 32-bit result. Other behaviour can only be shown by the bench's scenarios: exact product values against a model for signs, extremes and zero, the exact latency in edges, the word-enable encoding for even and odd destinations, and the proof that a start pushed in mid-operation changes neither the result nor the number of pulses.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_flags_t;

    localparam logic [1:0] WE_BOTH = 2'b11;
    localparam logic [1:0] WE_LOW  = 2'b01;

    function automatic logic [31:0] twos_neg32(input logic [31:0] x);
        return ~x + 32'd1;
    endfunction

endpackage

// File: rtl/mulseq_prep.sv
module mulseq_prep #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg_res
);
    always_comb begin
        mag_a   = a[W-1] ? (~a + W'(1)) : a;
        mag_b   = b[W-1] ? (~b + W'(1)) : b;
        neg_res = a[W-1] ^ b[W-1];
    end
endmodule

// File: rtl/mulseq_core.sv
module mulseq_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic [2*W-1:0] prod,
    output logic         fin
);
    localparam int ITERS = W + 1;
    localparam int CW    = $clog2(ITERS + 1);

    logic           run_q;
    logic           fin_q;
    logic [CW-1:0]  cnt_q;
    logic           cy_q;
    logic [W-1:0]   hi_q;
    logic [W-1:0]   lo_q;
    logic [W-1:0]   mc_q;

    logic [W-1:0]   hi_sh;
    logic [W-1:0]   lo_sh;
    logic           bit_out;
    logic [W:0]     sum;

    always_comb begin
        hi_sh   = {cy_q, hi_q[W-1:1]};
        lo_sh   = {hi_q[0], lo_q[W-1:1]};
        bit_out = lo_q[0];
        sum     = {1'b0, hi_sh} + {1'b0, mc_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            fin_q <= 1'b0;
            cnt_q <= '0;
            cy_q  <= 1'b0;
            hi_q  <= '0;
            lo_q  <= '0;
            mc_q  <= '0;
        end else if (load) begin
            run_q <= 1'b1;
            fin_q <= 1'b0;
            cnt_q <= '0;
            cy_q  <= 1'b0;
            hi_q  <= '0;
            lo_q  <= mplier;
            mc_q  <= mcand;
        end else if (run_q) begin
            lo_q <= lo_sh;
            if (bit_out) begin
                {cy_q, hi_q} <= sum;
            end else begin
                cy_q <= 1'b0;
                hi_q <= hi_sh;
            end
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == CW'(ITERS - 1)) begin
                run_q <= 1'b0;
                fin_q <= 1'b1;
            end
        end else begin
            fin_q <= 1'b0;
        end
    end

    assign prod = {hi_q, lo_q};
    assign fin  = fin_q;

    // R5
    no_carry_left_chk: assert property (@(posedge clk) disable iff (rst)
        fin_q |-> !cy_q);

    // R4
    iter_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q < CW'(ITERS)));
endmodule

// File: rtl/mulseq_fmt.sv
module mulseq_fmt
    import mulseq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2*W-1:0] mag_prod,
    input  logic           neg_res,
    input  logic           odd_dst,
    output logic [W-1:0]   hi,
    output logic [W-1:0]   lo,
    output cc_flags_t      flags,
    output logic [1:0]     we
);
    logic [2*W-1:0] full;

    always_comb begin
        full    = neg_res ? (~mag_prod + (2*W)'(1)) : mag_prod;
        hi      = full[2*W-1:W];
        lo      = full[W-1:0];
        flags.n = full[2*W-1];
        flags.z = (full == '0);
        flags.v = 1'b0;
        flags.c = (hi != {W{lo[W-1]}});
        we      = odd_dst ? WE_LOW : WE_BOTH;
    end
endmodule

// File: rtl/mulseq_top.sv
module mulseq_top
    import mulseq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         dst_odd,
    output logic         ready,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo,
    output logic [1:0]   wr_en,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_v,
    output logic         flag_c
);
    mul_state_e     st_q;
    logic           accept;
    logic           neg_q;
    logic           odd_q;
    logic           done_q;
    logic [W-1:0]   hi_q;
    logic [W-1:0]   lo_q;
    logic [1:0]     we_q;
    cc_flags_t      flg_q;

    logic [W-1:0]   mag_a;
    logic [W-1:0]   mag_b;
    logic           neg_now;
    logic [2*W-1:0] mag_prod;
    logic           core_fin;
    logic [W-1:0]   f_hi;
    logic [W-1:0]   f_lo;
    cc_flags_t      f_flags;
    logic [1:0]     f_we;

    assign accept = start && (st_q == ST_IDLE);

    mulseq_prep #(.W(W)) u_prep (
        .a       (op_a),
        .b       (op_b),
        .mag_a   (mag_a),
        .mag_b   (mag_b),
        .neg_res (neg_now)
    );

    mulseq_core #(.W(W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .mcand  (mag_a),
        .mplier (mag_b),
        .prod   (mag_prod),
        .fin    (core_fin)
    );

    mulseq_fmt #(.W(W)) u_fmt (
        .mag_prod (mag_prod),
        .neg_res  (neg_q),
        .odd_dst  (odd_q),
        .hi       (f_hi),
        .lo       (f_lo),
        .flags    (f_flags),
        .we       (f_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            neg_q  <= 1'b0;
            odd_q  <= 1'b0;
            done_q <= 1'b0;
            hi_q   <= '0;
            lo_q   <= '0;
            we_q   <= '0;
            flg_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        neg_q <= neg_now;
                        odd_q <= dst_odd;
                        st_q  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (core_fin) begin
                        hi_q   <= f_hi;
                        lo_q   <= f_lo;
                        we_q   <= f_we;
                        flg_q  <= f_flags;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign ready  = (st_q == ST_IDLE);
    assign busy   = (st_q == ST_RUN);
    assign done   = done_q;
    assign res_hi = hi_q;
    assign res_lo = lo_q;
    assign wr_en  = we_q;
    assign flag_n = flg_q.n;
    assign flag_z = flg_q.z;
    assign flag_v = flg_q.v;
    assign flag_c = flg_q.c;

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && ready) |=> (busy && !ready));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> ($stable(res_hi) && $stable(res_lo) && $stable(wr_en)));

    // R6
    zero_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (done && flag_z) |-> (!flag_n && !flag_c));

    // R10
    low_word_we_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> wr_en[0]);
endmodule

// File: tb/tb_mulseq_top.sv
module tb_mulseq_top;
    typedef struct packed {
        logic [15:0] hi;
        logic [15:0] lo;
        logic        n;
        logic        z;
        logic        v;
        logic        c;
        logic [1:0]  we;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        dst_odd = 1'b0;
    logic        ready, busy, done;
    logic [15:0] res_hi, res_lo;
    logic [1:0]  wr_en;
    logic        flag_n, flag_z, flag_v, flag_c;

    int n_run = 0;
    int n_fail = 0;
    exp_t exp_q[$];
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mulseq_top dut (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .dst_odd(dst_odd), .ready(ready), .busy(busy), .done(done),
        .res_hi(res_hi), .res_lo(res_lo), .wr_en(wr_en),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [15:0] a, input logic [15:0] b, input bit odd);
        exp_t e;
        logic signed [31:0] p;
        p    = $signed(a) * $signed(b);
        e.hi = p[31:16];
        e.lo = p[15:0];
        e.n  = p[31];
        e.z  = (p == 0);
        e.v  = 1'b0;
        e.c  = (p[31:16] != {16{p[15]}});
        e.we = odd ? 2'b01 : 2'b11;
        return e;
    endfunction

    // Monitor: compares every done against the scoreboard
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected done", {31'd0, done}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({res_hi, res_lo} == {e.hi, e.lo}, "R5 product", {res_hi, res_lo}, {e.hi, e.lo});
                chk(flag_z == e.z, "R6 zero flag", {31'd0, flag_z}, {31'd0, e.z});
                chk(flag_n == e.n, "R7 negative flag", {31'd0, flag_n}, {31'd0, e.n});
                chk(flag_v == 1'b0, "R8 overflow flag", {31'd0, flag_v}, 32'd0);
                chk(flag_c == e.c, "R9 carry flag", {31'd0, flag_c}, {31'd0, e.c});
                chk(wr_en == e.we, "R10 write enable", {30'd0, wr_en}, {30'd0, e.we});
            end
        end
    end

    // Driver: call at a negedge
    task automatic issue(input logic [15:0] a, input logic [15:0] b, input bit odd);
        while (!ready) @(negedge clk);
        op_a = a; op_b = b; dst_odd = odd; start = 1'b1;
        exp_q.push_back(model(a, b, odd));
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 100) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R4 actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        int lat;
        logic [15:0] keep_hi, keep_lo;
        repeat (5) @(negedge clk);
        // r1_reset
        chk(ready == 1'b1 && busy == 1'b0 && done == 1'b0, "R1 control after reset",
            {29'd0, ready, busy, done}, 32'h4);
        chk({res_hi, res_lo} == 32'd0 && wr_en == 2'd0, "R1 result after reset",
            {res_hi, res_lo}, 32'd0);
        chk({flag_n, flag_z, flag_v, flag_c} == 4'd0, "R1 flags after reset",
            {28'd0, flag_n, flag_z, flag_v, flag_c}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1, "R2 idle ready", {31'd0, ready}, 32'd1);

        // Latency and handshake
        issue(16'd300, 16'hFFF9, 1'b0);
        chk(busy && !ready, "R2 busy after accept", {30'd0, busy, ready}, 32'h2);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!done && lat < 40);
        chk(lat == 18, "R4 latency", lat, 32'd18);
        keep_hi = res_hi; keep_lo = res_lo;
        @(negedge clk);
        chk(!done, "R4 single-cycle done", {31'd0, done}, 32'd0);
        repeat (6) @(negedge clk);
        chk({res_hi, res_lo} == {keep_hi, keep_lo}, "R11 result held", {res_hi, res_lo}, {keep_hi, keep_lo});

        // Start while busy is ignored
        issue(16'h1234, 16'h0011, 1'b0);
        repeat (3) @(negedge clk);
        op_a = 16'h7FFF; op_b = 16'h7FFF; dst_odd = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !ready, "R3 still busy after ignored start", {30'd0, busy, ready}, 32'h2);
        wait_done();
        chk({res_hi, res_lo} == 32'h0001_3574 && wr_en == 2'b11, "R3 first operands kept",
            {res_hi, res_lo}, 32'h0001_3574);
        repeat (25) @(negedge clk);
        chk(exp_q.size() == 0 && !busy, "R3 no extra operation", {31'd0, busy}, 32'd0);

        // Directed corner operands
        issue(16'h8000, 16'h8000, 1'b0);
        issue(16'h8000, 16'hFFFF, 1'b1);
        issue(16'h8000, 16'h0001, 1'b0);
        issue(16'h7FFF, 16'h7FFF, 1'b0);
        issue(16'h0000, 16'hFFFF, 1'b0);
        issue(16'hFFFF, 16'h0000, 1'b1);
        issue(16'hFFFF, 16'hFFFF, 1'b1);
        issue(16'd181, 16'd181, 1'b0);
        issue(16'd182, 16'd181, 1'b0);
        issue(16'hFF4B, 16'd181, 1'b1);
        issue(16'h00FF, 16'hFF01, 1'b0);
        issue(16'd1, 16'd1, 1'b1);

        // Pseudo-random operands
        lfsr = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            logic [15:0] a, b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = (i % 3 == 0) ? {{10{lfsr[5]}}, lfsr[5:0]} : lfsr;
            issue(a, b, lfsr[0]);
        end

        while (exp_q.size() != 0) @(negedge clk);
        repeat (25) @(negedge clk);
        chk(!busy && ready, "R2 idle at end", {30'd0, busy, ready}, 32'h1);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule